// File: doc/BRIEF.md
# Dual-Slot In-Order Dispatch Gate

This block sits between the instruction queue and the execution units. Each cycle it decides whether the oldest queued instruction (slot 0) may leave the queue. If slot 0 leaves, it also decides whether the next instruction (slot 1) may leave in the same cycle. Instructions always leave in program order. Slot 1 is never sent on its own.

Each slot supplies the following:
- a valid bit;
- the ID of its target execution unit;
- how many integer (GPR) and floating-point (FPR) rename registers it needs;
- a serialization class.

The shared side supplies:
- a busy bit per execution unit;
- the free GPR and FPR rename counts;
- the number of free completion-queue entries;
- a flag showing that a completion-serialized instruction is executing.

Slot 0 is checked against these resources as given. Slot 1 is checked against what remains once slot 0 has taken its share.

The decision logic is combinational. A parameter selects whether the two dispatch strobes are registered (the default, for timing) or driven straight from the logic.

Top module: `dispatch_gate`

## Requirements
- R1: `disp0` is asserted only when `s0_valid` is 1 and the unit addressed by `s0_unit` has its `unit_busy` bit at 0.
- R2: `disp0` requires `s0_gpr_need <= gpr_free` and `s0_fpr_need <= fpr_free`.
- R3: `disp0` requires `cq_free >= 1`.
- R4: While `cser_active` is 1, neither strobe is asserted.
- R5: `disp1` is asserted only together with `disp0` and only when `s1_valid` is 1. If slot 0 cannot dispatch, slot 1 never dispatches alone.
- R6: Serialization class encoding is 0 = none, 1 = completion-serialized, 2 = refetch-serialized, 3 = treated as serializing. `disp1` requires `s0_ser == 0`.
- R7: `disp1` requires that `s1_unit` differs from `s0_unit` and that the slot 1 unit has its busy bit at 0. Every unit has a single instance.
- R8: `disp1` requires `s0_gpr_need + s1_gpr_need <= gpr_free` and `s0_fpr_need + s1_fpr_need <= fpr_free`.
- R9: A dual dispatch requires `cq_free >= 2`. With `cq_free == 1`, only slot 0 may dispatch.
- R10: With `REG_OUT = 1`, the strobes reflect the inputs sampled at the previous rising clock edge. While `rst_n` is 0, both strobes read 0.
- R11: A unit ID of `NUM_UNITS` or above names no unit, and that slot never dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_unit | input | UNIT_W | Slot 0 target execution unit ID |
| s0_gpr_need | input | NEED_W | GPR rename registers slot 0 needs |
| s0_fpr_need | input | NEED_W | FPR rename registers slot 0 needs |
| s0_ser | input | 2 | Slot 0 serialization class |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_unit | input | UNIT_W | Slot 1 target execution unit ID |
| s1_gpr_need | input | NEED_W | GPR rename registers slot 1 needs |
| s1_fpr_need | input | NEED_W | FPR rename registers slot 1 needs |
| s1_ser | input | 2 | Slot 1 serialization class (does not affect this cycle) |
| unit_busy | input | NUM_UNITS | One busy bit per execution unit |
| gpr_free | input | FREE_W | Free GPR rename registers |
| fpr_free | input | FREE_W | Free FPR rename registers |
| cq_free | input | CQ_W | Free completion-queue entries |
| cser_active | input | 1 | A completion-serialized instruction is executing |
| disp0 | output | 1 | Slot 0 dispatch strobe |
| disp1 | output | 1 | Slot 1 dispatch strobe |

## Verification
With the default registered output, both strobes for a given input pattern appear exactly one rising edge after that pattern is applied. Nothing in the block carries over to later cycles.

The bench drives each pattern at a falling edge and records the expected strobe pair. It compares that pair one nanosecond after the next rising edge, so every comparison falls in the one cycle where that pattern's result is visible. The reset check is taken at the same offset while reset is held with a dispatchable pattern on the inputs.

// File: rtl/dgate_pkg.sv
package dgate_pkg;
    localparam logic [1:0] SER_NONE    = 2'd0;
    localparam logic [1:0] SER_CMPL    = 2'd1;
    localparam logic [1:0] SER_REFETCH = 2'd2;

    typedef struct packed {
        logic disp0;
        logic disp1;
    } strobe_t;
endpackage

// File: rtl/dgate_slot_check.sv
module dgate_slot_check #(
    parameter int NUM_UNITS = 6,
    parameter int UNIT_W    = 3,
    parameter int NEED_W    = 2,
    parameter int FREE_W    = 4,
    parameter int CQ_W      = 3
) (
    input  logic                 valid,
    input  logic [UNIT_W-1:0]    unit,
    input  logic [NEED_W-1:0]    gpr_need,
    input  logic [NEED_W-1:0]    fpr_need,
    input  logic [NUM_UNITS-1:0] busy,
    input  logic [FREE_W-1:0]    gpr_avail,
    input  logic [FREE_W-1:0]    fpr_avail,
    input  logic [CQ_W-1:0]      cq_avail,
    output logic                 ok
);
    localparam int CMP_W = ((FREE_W > NEED_W) ? FREE_W : NEED_W) + 1;

    logic [NUM_UNITS-1:0] hit_free;
    logic                 unit_ok;
    logic                 gpr_ok;
    logic                 fpr_ok;

    // One comparator per unit; an ID outside the range matches none of them.
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
        assign hit_free[i] = (unit == UNIT_W'(i)) && !busy[i];
    end

    always_comb begin
        unit_ok = |hit_free;
        gpr_ok  = CMP_W'(gpr_need) <= CMP_W'(gpr_avail);
        fpr_ok  = CMP_W'(fpr_need) <= CMP_W'(fpr_avail);
        ok      = valid && unit_ok && gpr_ok && fpr_ok && (cq_avail != '0);
    end
endmodule

// File: rtl/dgate_remainder.sv
module dgate_remainder #(
    parameter int NUM_UNITS = 6,
    parameter int UNIT_W    = 3,
    parameter int NEED_W    = 2,
    parameter int FREE_W    = 4,
    parameter int CQ_W      = 3
) (
    input  logic [UNIT_W-1:0]    s0_unit,
    input  logic [NEED_W-1:0]    s0_gpr_need,
    input  logic [NEED_W-1:0]    s0_fpr_need,
    input  logic [NUM_UNITS-1:0] busy_in,
    input  logic [FREE_W-1:0]    gpr_in,
    input  logic [FREE_W-1:0]    fpr_in,
    input  logic [CQ_W-1:0]      cq_in,
    output logic [NUM_UNITS-1:0] busy_left,
    output logic [FREE_W-1:0]    gpr_left,
    output logic [FREE_W-1:0]    fpr_left,
    output logic [CQ_W-1:0]      cq_left
);
    localparam int CMP_W = ((FREE_W > NEED_W) ? FREE_W : NEED_W) + 1;

    logic [CMP_W-1:0] gpr_diff;
    logic [CMP_W-1:0] fpr_diff;

    // Slot 0 occupies its unit: mark it busy for slot 1.
    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_claim
        assign busy_left[i] = busy_in[i] || (s0_unit == UNIT_W'(i));
    end

    always_comb begin
        gpr_diff = CMP_W'(gpr_in) - CMP_W'(s0_gpr_need);
        fpr_diff = CMP_W'(fpr_in) - CMP_W'(s0_fpr_need);
        // Saturate at zero; a shortfall already blocks slot 0 and hence slot 1.
        gpr_left = gpr_diff[CMP_W-1] ? '0 : gpr_diff[FREE_W-1:0];
        fpr_left = fpr_diff[CMP_W-1] ? '0 : fpr_diff[FREE_W-1:0];
        cq_left  = (cq_in == '0) ? '0 : cq_in - CQ_W'(1);
    end
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
    import dgate_pkg::*;
#(
    parameter int NUM_UNITS = 6,
    parameter int UNIT_W    = 3,
    parameter int NEED_W    = 2,
    parameter int FREE_W    = 4,
    parameter int CQ_W      = 3,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s0_valid,
    input  logic [UNIT_W-1:0]    s0_unit,
    input  logic [NEED_W-1:0]    s0_gpr_need,
    input  logic [NEED_W-1:0]    s0_fpr_need,
    input  logic [1:0]           s0_ser,
    input  logic                 s1_valid,
    input  logic [UNIT_W-1:0]    s1_unit,
    input  logic [NEED_W-1:0]    s1_gpr_need,
    input  logic [NEED_W-1:0]    s1_fpr_need,
    input  logic [1:0]           s1_ser,
    input  logic [NUM_UNITS-1:0] unit_busy,
    input  logic [FREE_W-1:0]    gpr_free,
    input  logic [FREE_W-1:0]    fpr_free,
    input  logic [CQ_W-1:0]      cq_free,
    input  logic                 cser_active,
    output logic                 disp0,
    output logic                 disp1
);
    localparam int SUM_W = ((FREE_W > NEED_W) ? FREE_W : NEED_W) + 2;

    logic                 ok0_raw;
    logic                 ok1_raw;
    logic [NUM_UNITS-1:0] busy_left;
    logic [FREE_W-1:0]    gpr_left;
    logic [FREE_W-1:0]    fpr_left;
    logic [CQ_W-1:0]      cq_left;
    strobe_t              strobe_d;
    logic                 s1_ser_unused;

    // The slot 1 class only matters once it moves into slot 0.
    assign s1_ser_unused = ^s1_ser;

    dgate_slot_check #(
        .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .NEED_W(NEED_W),
        .FREE_W(FREE_W), .CQ_W(CQ_W)
    ) u_chk0 (
        .valid(s0_valid), .unit(s0_unit),
        .gpr_need(s0_gpr_need), .fpr_need(s0_fpr_need),
        .busy(unit_busy), .gpr_avail(gpr_free), .fpr_avail(fpr_free),
        .cq_avail(cq_free), .ok(ok0_raw)
    );

    dgate_remainder #(
        .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .NEED_W(NEED_W),
        .FREE_W(FREE_W), .CQ_W(CQ_W)
    ) u_rem (
        .s0_unit(s0_unit), .s0_gpr_need(s0_gpr_need), .s0_fpr_need(s0_fpr_need),
        .busy_in(unit_busy), .gpr_in(gpr_free), .fpr_in(fpr_free), .cq_in(cq_free),
        .busy_left(busy_left), .gpr_left(gpr_left), .fpr_left(fpr_left),
        .cq_left(cq_left)
    );

    dgate_slot_check #(
        .NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .NEED_W(NEED_W),
        .FREE_W(FREE_W), .CQ_W(CQ_W)
    ) u_chk1 (
        .valid(s1_valid), .unit(s1_unit),
        .gpr_need(s1_gpr_need), .fpr_need(s1_fpr_need),
        .busy(busy_left), .gpr_avail(gpr_left), .fpr_avail(fpr_left),
        .cq_avail(cq_left), .ok(ok1_raw)
    );

    // Next-value logic: in-order chaining and serialization gating.
    always_comb begin
        strobe_d       = '0;
        strobe_d.disp0 = ok0_raw && !cser_active;
        strobe_d.disp1 = strobe_d.disp0 && ok1_raw && (s0_ser == SER_NONE);
    end

    if (REG_OUT) begin : g_reg
        strobe_t strobe_q;

        always_ff @(posedge clk) begin
            if (!rst_n) strobe_q <= '0;
            else        strobe_q <= strobe_d;
        end

        assign disp0 = strobe_q.disp0;
        assign disp1 = strobe_q.disp1;

        p_cser_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            disp0 |-> !$past(cser_active));
        p_pair_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
            disp1 |-> disp0);
        p_serial_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
            disp1 |-> ($past(s0_ser) == SER_NONE));
        p_distinct_units_r7: assert property (@(posedge clk) disable iff (!rst_n)
            disp1 |-> ($past(s0_unit) != $past(s1_unit)));
        p_rename_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
            disp1 |-> ((SUM_W'($past(s0_gpr_need)) + SUM_W'($past(s1_gpr_need)))
                       <= SUM_W'($past(gpr_free))));
        p_cq_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
            disp1 |-> ($past(cq_free) >= CQ_W'(2)));
        p_unit_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
            disp0 |-> (32'($past(s0_unit)) < NUM_UNITS));
    end else begin : g_comb
        assign disp0 = strobe_d.disp0;
        assign disp1 = strobe_d.disp1;

        always_comb begin
            a_pair_order_r5: assert (!(disp1 && !disp0));
        end
    end
endmodule

// File: tb/dispatch_gate_tb_top.sv
`timescale 1ns/1ps
module dispatch_gate_tb_top;
    localparam int NU = 6, UW = 3, NW = 2, FW = 4, CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          v0, v1, cs;
    logic [UW-1:0] u0, u1;
    logic [NW-1:0] g0, f0, g1, f1;
    logic [1:0]    sr0, sr1;
    logic [NU-1:0] busy;
    logic [FW-1:0] gf, ff;
    logic [CW-1:0] cq;
    logic          disp0, disp1;

    // Staged stimulus, copied onto the DUT inputs at a falling edge.
    logic          t_v0, t_v1, t_cs;
    logic [UW-1:0] t_u0, t_u1;
    logic [NW-1:0] t_g0, t_f0, t_g1, t_f1;
    logic [1:0]    t_sr0, t_sr1;
    logic [NU-1:0] t_busy;
    logic [FW-1:0] t_gf, t_ff;
    logic [CW-1:0] t_cq;

    dispatch_gate #(.NUM_UNITS(NU), .UNIT_W(UW), .NEED_W(NW), .FREE_W(FW),
                    .CQ_W(CW), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(v0), .s0_unit(u0), .s0_gpr_need(g0), .s0_fpr_need(f0), .s0_ser(sr0),
        .s1_valid(v1), .s1_unit(u1), .s1_gpr_need(g1), .s1_fpr_need(f1), .s1_ser(sr1),
        .unit_busy(busy), .gpr_free(gf), .fpr_free(ff), .cq_free(cq),
        .cser_active(cs), .disp0(disp0), .disp1(disp1)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    // Reference decision, written from the requirement list.
    function automatic logic [1:0] model();
        logic a, b;
        a = v0 && (int'(u0) < NU) && !busy[int'(u0) % NU] && (g0 <= gf) && (f0 <= ff)
            && (cq >= 1) && !cs;
        b = a && v1 && (sr0 == 2'd0) && (int'(u1) < NU) && (u1 != u0)
            && !busy[int'(u1) % NU] && (int'(g0) + int'(g1) <= int'(gf))
            && (int'(f0) + int'(f1) <= int'(ff)) && (cq >= 2);
        return {a, b};
    endfunction

    task automatic base();
        t_v0 = 1; t_u0 = 0; t_g0 = 1; t_f0 = 0; t_sr0 = 0;
        t_v1 = 1; t_u1 = 1; t_g1 = 1; t_f1 = 1; t_sr1 = 0;
        t_busy = '0; t_gf = 4; t_ff = 4; t_cq = 3; t_cs = 0;
    endtask

    task automatic apply();
        v0 = t_v0; u0 = t_u0; g0 = t_g0; f0 = t_f0; sr0 = t_sr0;
        v1 = t_v1; u1 = t_u1; g1 = t_g1; f1 = t_f1; sr1 = t_sr1;
        busy = t_busy; gf = t_gf; ff = t_ff; cq = t_cq; cs = t_cs;
    endtask

    // Driver: one pattern per cycle, expected pair pushed to the scoreboard.
    task automatic step(input string tag, input logic [1:0] hand_exp);
        @(negedge clk);
        apply();
        if (model() !== hand_exp)
            $display("[TB] note: hand value differs from model for %s", tag);
        exp_q.push_back(hand_exp);
        tag_q.push_back(tag);
    endtask

    task automatic step_rnd();
        @(negedge clk);
        apply();
        exp_q.push_back(model());
        tag_q.push_back("R1 R2 R3 R7 R8 R9 random");
    endtask

    // Monitor: compare 1 ns after the edge that registers each pattern.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_tests++;
                if ({disp0, disp1} !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b%b expected %b", t, disp0, disp1, e);
                end
            end
        end
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        base(); apply();
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if ({disp0, disp1} !== 2'b00) begin
            n_fail++;
            $display("FAIL R10 reset: got %b%b expected 00", disp0, disp1);
        end
        @(negedge clk); rst_n = 1'b1;

        base();                step("R5 R10 dual dispatch", 2'b11);
        base(); t_busy[0] = 1; step("R1 slot0 unit busy", 2'b00);
        base(); t_v0 = 0;      step("R1 R5 slot0 empty, slot1 alone", 2'b00);
        base(); t_u0 = 7;      step("R11 slot0 unit out of range", 2'b00);
        base(); t_u1 = 6;      step("R11 slot1 unit out of range", 2'b10);
        base(); t_gf = 0;      step("R2 no GPR rename", 2'b00);
        base(); t_f0 = 2; t_ff = 1; step("R2 FPR shortfall", 2'b00);
        base(); t_cq = 0;      step("R3 completion queue full", 2'b00);
        base(); t_cs = 1;      step("R4 completion-serialized executing", 2'b00);
        base(); t_sr0 = 1;     step("R6 slot0 completion-serialized", 2'b10);
        base(); t_sr0 = 2;     step("R6 slot0 refetch-serialized", 2'b10);
        base(); t_sr0 = 3;     step("R6 slot0 class 3", 2'b10);
        base(); t_sr1 = 2;     step("R6 slot1 class ignored", 2'b11);
        base(); t_u1 = 0;      step("R7 same unit", 2'b10);
        base(); t_busy[1] = 1; step("R7 slot1 unit busy", 2'b10);
        base(); t_g1 = 2; t_gf = 2; step("R8 GPR left short", 2'b10);
        base(); t_g1 = 2; t_gf = 3; step("R8 GPR exact fit", 2'b11);
        base(); t_f0 = 2; t_f1 = 2; t_ff = 3; step("R8 FPR left short", 2'b10);
        base(); t_cq = 1;      step("R9 one free CQ entry", 2'b10);
        base(); t_cq = 2;      step("R9 two free CQ entries", 2'b11);
        base(); t_v1 = 0;      step("R5 slot1 empty", 2'b10);
        base(); t_cs = 1; t_sr0 = 1; step("R4 both blocked", 2'b00);

        for (int i = 0; i < 400; i++) begin
            t_v0 = 1'($urandom); t_v1 = 1'($urandom); t_cs = ($urandom % 8) == 0;
            t_u0 = UW'($urandom % 7); t_u1 = UW'($urandom % 7);
            t_g0 = NW'($urandom); t_f0 = NW'($urandom);
            t_g1 = NW'($urandom); t_f1 = NW'($urandom);
            t_sr0 = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
            t_sr1 = 2'($urandom);
            t_busy = NU'($urandom) & NU'($urandom);
            t_gf = FW'($urandom % 8); t_ff = FW'($urandom % 8);
            t_cq = CW'($urandom % 4);
            step_rnd();
        end

        @(posedge clk); #2;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule